// File: doc/BRIEF.md
# Video superimposition key generator

This block decides, for every pixel, whether the graphics plane or an external video source is shown. A pixel colour (4 bits each of red, green and blue) and a per-pixel transparency value arrive on each clock. The block compares the colour with either a border colour or a chroma-key colour and produces two outputs: a one-bit overlay select (1 = show graphics, 0 = show external video) and a 6-bit transparency code for downstream mixing.

Comparison only takes place while superimposition is enabled. If the selected comparison does not apply, a fallback bit sets the whole screen to one state. When transparency is enabled, background pixels take a programmed background transparency. Both outputs then pass through a tap-selectable delay of 0 to 7 clocks, which lines them up with the video pipeline. A setting of 4 matches the video output.

Top module: `ovl_key_gen`

## Requirements
- R1: When `sup_en` is 0, `key_show` is 1 and `key_trans` is 0, whatever the other inputs are.
- R2: When `sup_en` and `trans_en` are 1 and `cmp_mode[1:0]` is 00 or 10, no comparison is made and `key_show` equals the fallback bit `cmp_mode[2]`.
- R3: When `sup_en` and `trans_en` are 1, `cmp_mode[1:0]` is 01 and `border_rgb` is not 12'h000, `key_show` is 1 for a pixel whose 12-bit colour differs from `border_rgb` and 0 for one that matches it.
- R4: When `sup_en` and `trans_en` are 1, `cmp_mode[1:0]` is 01 and `border_rgb` is 12'h000, `key_show` equals `cmp_mode[2]`.
- R5: When `sup_en` and `trans_en` are 1 and `cmp_mode[1:0]` is 11, `key_show` is 0 only when all 12 bits of `pix_rgb` equal `key_rgb`, and 1 otherwise. The fallback bit has no effect in this mode.
- R6: When `sup_en` is 1 and `trans_en` is 0, `key_show` is 1 and `key_trans` is 0.
- R7: When `sup_en` and `trans_en` are 1, `key_trans` is `bg_trans` for a pixel with `pix_bg` = 1 and `pix_trans` otherwise.
- R8: Both outputs show the result for the inputs applied `out_phase` clocks earlier. With `out_phase` = 0 the path is combinational. A setting of 4 is the one aligned with the video output.
- R9: Reset clears every delay stage, so after reset and at any nonzero `out_phase` the outputs read `key_show` = 0 and `key_trans` = 0 until new results have moved through the stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock (four times the subcarrier) |
| rst_n | input | 1 | Active-low synchronous reset |
| sup_en | input | 1 | Superimposition enable |
| cmp_mode | input | 3 | [1:0] comparison select, [2] whole-screen fallback |
| trans_en | input | 1 | Transparency output enable |
| bg_trans | input | 6 | Transparency used for background pixels |
| out_phase | input | 3 | Output delay in clocks, 0 to 7 |
| pix_rgb | input | 12 | Current pixel colour {R,G,B} |
| pix_bg | input | 1 | Current pixel is background |
| pix_trans | input | 6 | Per-pixel transparency |
| border_rgb | input | 12 | Border colour |
| key_rgb | input | 12 | Chroma-key colour |
| key_show | output | 1 | Overlay select, 1 = graphics shown |
| key_trans | output | 6 | Transparency output |

## Verification
A wrong decision in the comparison logic shows up on `key_show` after exactly `out_phase` clocks, and in the same cycle when the phase is 0. A black border or a pixel equal to the key colour is enough to expose it. A stuck or skipped delay stage shows up as a result taken from the wrong earlier cycle at one particular phase setting. A stage that is not cleared shows up as a nonzero output in the first few cycles after reset. The bench therefore sweeps every phase value and uses pixel streams that change on every clock, so each stage carries a distinct value.

// File: rtl/ovl_key_pkg.sv
package ovl_key_pkg;
  localparam int COLOR_W = 12;
  localparam int TRANS_W = 6;

  typedef enum logic [1:0] {
    CMP_NONE   = 2'b00,
    CMP_BORDER = 2'b01,
    CMP_SPARE  = 2'b10,
    CMP_CHROMA = 2'b11
  } cmp_sel_e;

  // Overlay decision for one pixel; 1 = graphics shown.
  function automatic logic ovl_decide(
    input logic               sup_en,
    input logic               trans_en,
    input logic [2:0]         mode,
    input logic [COLOR_W-1:0] pix,
    input logic [COLOR_W-1:0] border,
    input logic [COLOR_W-1:0] key
  );
    logic fallback;
    fallback = mode[2];
    if (!sup_en || !trans_en) return 1'b1;
    case (cmp_sel_e'(mode[1:0]))
      CMP_BORDER: return (border == '0) ? fallback : (pix != border);
      CMP_CHROMA: return (pix != key);
      default:    return fallback;
    endcase
  endfunction

  function automatic logic [TRANS_W-1:0] trans_pick(
    input logic               sup_en,
    input logic               trans_en,
    input logic               is_bg,
    input logic [TRANS_W-1:0] bg_val,
    input logic [TRANS_W-1:0] pix_val
  );
    if (!sup_en || !trans_en) return '0;
    return is_bg ? bg_val : pix_val;
  endfunction
endpackage

// File: rtl/ovl_key_decide.sv
module ovl_key_decide
  import ovl_key_pkg::*;
(
  input  logic               sup_en,
  input  logic [2:0]         cmp_mode,
  input  logic               trans_en,
  input  logic [TRANS_W-1:0] bg_trans,
  input  logic [COLOR_W-1:0] pix_rgb,
  input  logic               pix_bg,
  input  logic [TRANS_W-1:0] pix_trans,
  input  logic [COLOR_W-1:0] border_rgb,
  input  logic [COLOR_W-1:0] key_rgb,
  output logic               show,
  output logic [TRANS_W-1:0] trans
);
  always_comb begin
    show  = ovl_decide(sup_en, trans_en, cmp_mode, pix_rgb, border_rgb, key_rgb);
    trans = trans_pick(sup_en, trans_en, pix_bg, bg_trans, pix_trans);
  end
endmodule

// File: rtl/ovl_key_delay.sv
module ovl_key_delay #(
  parameter int W       = 7,
  parameter int PHASE_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PHASE_W-1:0] phase,
  input  logic [W-1:0]       din,
  output logic [W-1:0]       dout
);
  localparam int DEPTH = 1 << PHASE_W;

  logic [W-1:0] tap [DEPTH];
  assign tap[0] = din;

  for (genvar k = 1; k < DEPTH; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) tap[k] <= '0;
      else        tap[k] <= tap[k-1];
    end
  end

  assign dout = tap[phase];

  // One clean edge has passed since reset, so $past(din) is meaningful.
  logic primed;
  always_ff @(posedge clk) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  a_r8_tap_zero_direct: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == '0) |-> (dout == din));
  a_r8_tap_one_prev: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && phase == PHASE_W'(1)) |-> (dout == $past(din)));
  a_r9_clear_after_reset: assert property (@(posedge clk)
    (!rst_n && phase != '0) |=> (dout == '0));
endmodule

// File: rtl/ovl_key_gen.sv
module ovl_key_gen
  import ovl_key_pkg::*;
#(
  parameter int PHASE_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sup_en,
  input  logic [2:0]         cmp_mode,
  input  logic               trans_en,
  input  logic [5:0]         bg_trans,
  input  logic [PHASE_W-1:0] out_phase,
  input  logic [11:0]        pix_rgb,
  input  logic               pix_bg,
  input  logic [5:0]         pix_trans,
  input  logic [11:0]        border_rgb,
  input  logic [11:0]        key_rgb,
  output logic               key_show,
  output logic [5:0]         key_trans
);
  localparam int PW = TRANS_W + 1;

  logic               now_show;
  logic [TRANS_W-1:0] now_trans;
  logic [PW-1:0]      dly_out;

  ovl_key_decide u_decide (
    .sup_en    (sup_en),
    .cmp_mode  (cmp_mode),
    .trans_en  (trans_en),
    .bg_trans  (bg_trans),
    .pix_rgb   (pix_rgb),
    .pix_bg    (pix_bg),
    .pix_trans (pix_trans),
    .border_rgb(border_rgb),
    .key_rgb   (key_rgb),
    .show      (now_show),
    .trans     (now_trans)
  );

  ovl_key_delay #(.W(PW), .PHASE_W(PHASE_W)) u_delay (
    .clk  (clk),
    .rst_n(rst_n),
    .phase(out_phase),
    .din  ({now_show, now_trans}),
    .dout (dly_out)
  );

  assign key_show  = dly_out[PW-1];
  assign key_trans = dly_out[TRANS_W-1:0];

  a_r1_disabled_shows: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_en |-> (now_show && now_trans == '0));
  a_r6_trans_off_shows: assert property (@(posedge clk) disable iff (!rst_n)
    (sup_en && !trans_en) |-> (now_show && now_trans == '0));
  a_r5_key_match_hides: assert property (@(posedge clk) disable iff (!rst_n)
    (sup_en && trans_en && cmp_mode[1:0] == 2'b11 && pix_rgb == key_rgb) |-> !now_show);
  a_r4_black_border_fallback: assert property (@(posedge clk) disable iff (!rst_n)
    (sup_en && trans_en && cmp_mode[1:0] == 2'b01 && border_rgb == '0)
      |-> (now_show == cmp_mode[2]));
  a_r7_bg_uses_setting: assert property (@(posedge clk) disable iff (!rst_n)
    (sup_en && trans_en && pix_bg) |-> (now_trans == bg_trans));
endmodule

// File: tb/tb_ovl_key_gen.sv
module tb_ovl_key_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sup_en, trans_en, pix_bg;
  logic [2:0]  cmp_mode, out_phase;
  logic [5:0]  bg_trans, pix_trans;
  logic [11:0] pix_rgb, border_rgb, key_rgb;
  logic        key_show;
  logic [5:0]  key_trans;

  always #2.5 clk = ~clk;

  ovl_key_gen dut (
    .clk(clk), .rst_n(rst_n), .sup_en(sup_en), .cmp_mode(cmp_mode),
    .trans_en(trans_en), .bg_trans(bg_trans), .out_phase(out_phase),
    .pix_rgb(pix_rgb), .pix_bg(pix_bg), .pix_trans(pix_trans),
    .border_rgb(border_rgb), .key_rgb(key_rgb),
    .key_show(key_show), .key_trans(key_trans)
  );

  int tests = 0;
  int fails = 0;
  logic [6:0] hist [7];   // hist[j]: expected {show,trans} for inputs j+1 clocks back

  // Expected {show,trans} from the requirements.
  function automatic logic [6:0] model();
    logic s;
    logic [5:0] t;
    s = 1'b1; t = 6'd0;                              // R1, R6
    if (sup_en && trans_en) begin
      t = pix_bg ? bg_trans : pix_trans;             // R7
      if (cmp_mode[1:0] == 2'b11)      s = (pix_rgb != key_rgb);          // R5
      else if (cmp_mode[1:0] == 2'b01 && border_rgb != 12'd0)
                                       s = (pix_rgb != border_rgb);       // R3
      else                             s = cmp_mode[2];                   // R2, R4
    end
    return {s, t};
  endfunction

  task automatic check(input string req, input logic [6:0] exp);
    tests++;
    if ({key_show, key_trans} !== exp) begin
      fails++;
      $display("FAIL %s: got show=%0b trans=%0d, expected show=%0b trans=%0d",
               req, key_show, key_trans, exp[6], exp[5:0]);
    end
  endtask

  // Drive at negedge, check shortly before posedge, then advance history.
  task automatic step(input string req);
    logic [6:0] now_e;
    now_e = model();
    #1.5;
    check(req, (out_phase == 3'd0) ? now_e : hist[out_phase - 3'd1]);
    @(posedge clk);
    for (int j = 6; j > 0; j--) hist[j] = hist[j-1];
    hist[0] = now_e;
    @(negedge clk);
  endtask

  task automatic rand_pix();
    logic [3:0] c;
    c = 4'($urandom_range(0, 15));
    if (c < 4)      pix_rgb = border_rgb;
    else if (c < 8) pix_rgb = key_rgb;
    else if (c < 9) pix_rgb = key_rgb ^ 12'h001;
    else            pix_rgb = 12'($urandom);
    pix_bg    = 1'($urandom);
    pix_trans = 6'($urandom);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int j = 0; j < 7; j++) hist[j] = 7'd0;
    rst_n = 1'b0; sup_en = 1'b1; trans_en = 1'b1; cmp_mode = 3'b111;
    out_phase = 3'd3; bg_trans = 6'h15; pix_trans = 6'h2a; pix_bg = 1'b0;
    pix_rgb = 12'h123; border_rgb = 12'h456; key_rgb = 12'h789;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1.5; check("R9 reset state", 7'd0);
    @(negedge clk);
    rst_n = 1'b1;
    // R9: cleared stages show through at phase 3 for three clocks
    for (int i = 0; i < 5; i++) begin
      pix_rgb = 12'(i * 37 + 1);
      step("R9 cleared stages");
    end
    // Directed corners at phase 0
    out_phase = 3'd0;
    sup_en = 1'b0; cmp_mode = 3'b011; pix_rgb = key_rgb; step("R1 disabled");
    sup_en = 1'b1; trans_en = 1'b0; step("R6 trans off");
    trans_en = 1'b1; step("R5 key match");
    cmp_mode = 3'b111; step("R5 fallback ignored");
    pix_rgb = key_rgb ^ 12'h800; step("R5 one bit differs");
    cmp_mode = 3'b001; border_rgb = 12'h000; pix_rgb = 12'h000; step("R4 black border G0");
    cmp_mode = 3'b101; step("R4 black border G1");
    border_rgb = 12'h00f; pix_rgb = 12'h00f; step("R3 border match");
    pix_rgb = 12'h00e; step("R3 border differs");
    cmp_mode = 3'b000; step("R2 mode 00 G0");
    cmp_mode = 3'b110; step("R2 mode 10 G1");
    pix_bg = 1'b1; step("R7 background value");
    pix_bg = 1'b0; step("R7 pixel value");
    // Random sweep across every phase, including 4 (video aligned)
    for (int p = 0; p < 8; p++) begin
      out_phase = 3'(p);
      for (int i = 0; i < 300; i++) begin
        sup_en   = ($urandom_range(0, 7) != 0);
        trans_en = ($urandom_range(0, 7) != 0);
        cmp_mode = 3'($urandom);
        bg_trans = 6'($urandom);
        border_rgb = ($urandom_range(0, 3) == 0) ? 12'h000 : 12'($urandom);
        if ($urandom_range(0, 15) == 0) key_rgb = 12'($urandom);
        rand_pix();
        step("R8 delayed result");
      end
    end
    // Phase change mid-stream: all taps keep their history
    for (int i = 0; i < 50; i++) begin
      out_phase = 3'($urandom);
      rand_pix();
      step("R8 phase change");
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule